// File: doc/BRIEF.md
# PRBS-7 Pattern Generator and Bit-Error Checker

This block is a built-in bit-error-rate test engine for a serial link's parallel side. While its enable is high, the transmit half produces a maximal-length pseudorandom sequence with a period of 127 bits. It emits that sequence as one 10-bit word per clock, so the word can replace normal traffic on the transmitter's parallel input. The receive half takes one received 10-bit word per clock and locks onto the incoming stream by itself. It does this by loading its history from the first seven received bits. It then predicts every later bit from the bits it has already received and flags any word that holds a wrong bit.

The result is a single status output: high means pass, low means an error was seen. A mode input selects between two behaviours. In the first, the status shows the result of the most recent word. In the second, the first error pulls the status low and it stays low until the test is stopped. Dropping the enable returns both halves to idle and clears any held failure.

Top module: `prbs7_bert`

## Requirements
- R1: While `prbs_en` is low at a clock edge, `tx_word` is all zeros and `status_ok` is high from that edge on, and `rx_word` has no effect on either.
- R2: Generated bits follow b[n] = b[n-6] xor b[n-7]. Each time `prbs_en` is first sampled high, the sequence restarts as if the seven bits before it were all ones. Bit 0 of each word is the earliest bit. The first word appears on `tx_word` after that edge and a new word follows on every edge, starting 10'h040, 10'h10C.
- R3: The generated word stream repeats with a period of 127 words, so word 127 equals word 0.
- R4: The checker takes the first seven received bits after `prbs_en` goes high (bit 0 of each word first) as its seed without checking them, so a clean sequence entered at any phase reports no error.
- R5: Every later received bit is compared with the xor of the received bits six and seven positions before it. A single mismatch makes that word fail, and a failed word drives `status_ok` low at the next edge.
- R6: `status_ok` reflects a received word from the clock edge that samples it; before that edge it still shows the earlier result.
- R7: With `latch_fail` low, `status_ok` is high exactly when the last sampled word passed, so it recovers after an error.
- R8: With `latch_fail` high, once `status_ok` is low it stays low for as long as `prbs_en` stays high.
- R9: Sampling `prbs_en` low clears a held failure and restarts seeding for the next test.
- R10: A synchronous active-low `rst_n` sets `tx_word` to zero and `status_ok` high, clearing a held failure.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Word clock |
| rst_n | input | 1 | Synchronous reset, active low |
| prbs_en | input | 1 | Enables generation and checking; low means idle |
| latch_fail | input | 1 | High: hold the first failure; low: show the last word's result |
| rx_word | input | WORD_W | Received word, bit 0 earliest |
| tx_word | output | WORD_W | Generated word, bit 0 earliest |
| status_ok | output | 1 | High = pass, low = error detected |

## Verification
The checker is given clean sequences entered at several phases, so that any seeding that depends on the starting phase would show up as a false failure. It is also given streams with one flipped bit: in the seed, in the first checked bits, and at the last bit of a word. These show whether a fault that carries across a word boundary through the history is seen, and whether an error near the seed is missed. Each faulty stream runs once in live mode and once in held mode, which tells recovery apart from holding. The generator's words are compared each cycle with an independent model of the recurrence, including the wrap after 127 words.

// File: rtl/prbs7_pkg.sv
// Shared constants and helpers for the PRBS-7 test engine.
// Assumes the history register keeps the newest bit in position 0.
package prbs7_pkg;
    localparam int ORDER    = 7;   // register length of the sequence
    localparam int TAP_FAR  = 7;   // x^7 term: bit seven positions back
    localparam int TAP_NEAR = 6;   // x^6 term: bit six positions back
    localparam int SEED_CW  = $clog2(ORDER + 1);

    typedef logic [ORDER-1:0] hist_t;

    // Predicted next bit from a history of earlier bits.
    function automatic logic predict_bit(hist_t h);
        return h[TAP_FAR-1] ^ h[TAP_NEAR-1];
    endfunction

    // Push a new bit into the history, dropping the oldest.
    function automatic hist_t push_bit(hist_t h, logic b);
        return {h[ORDER-2:0], b};
    endfunction
endpackage

// File: rtl/prbs7_tx_gen.sv
// Transmit pattern source: emits WORD_W sequence bits per clock while enabled,
// bit 0 earliest. Restarts from an all-ones history whenever disabled.
// Assumes WORD_W >= 7 so no generated word can be all zeros.
module prbs7_tx_gen
    import prbs7_pkg::*;
#(
    parameter int WORD_W = 10
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              prbs_en,
    output logic [WORD_W-1:0] tx_word
);
    hist_t             gen_q;
    hist_t             gen_n;
    logic [WORD_W-1:0] word_n;

    // Unroll WORD_W steps of the recurrence for one word.
    always_comb begin
        hist_t h;
        logic  b;
        h      = gen_q;
        word_n = '0;
        for (int i = 0; i < WORD_W; i++) begin
            b         = predict_bit(h);
            word_n[i] = b;
            h         = push_bit(h, b);
        end
        gen_n = h;
    end

    // Hold the history and register the outgoing word.
    always_ff @(posedge clk) begin
        if (!rst_n || !prbs_en) begin
            gen_q   <= '1;
            tx_word <= '0;
        end else begin
            gen_q   <= gen_n;
            tx_word <= word_n;
        end
    end
endmodule

// File: rtl/prbs7_rx_chk.sv
// Receive checker: seeds its history from the first ORDER received bits, then
// compares each later bit with the prediction. Self-synchronizing: the history
// always takes the received bit, right or wrong. word_err is combinational.
module prbs7_rx_chk
    import prbs7_pkg::*;
#(
    parameter int WORD_W = 10
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              prbs_en,
    input  logic [WORD_W-1:0] rx_word,
    output logic              word_err
);
    hist_t              hist_q;
    hist_t              hist_n;
    logic [SEED_CW-1:0] seed_q;
    logic [SEED_CW-1:0] seed_n;
    logic               err_raw;

    // Walk the word bit by bit: seed first, then predict and compare.
    always_comb begin
        hist_t              h;
        logic [SEED_CW-1:0] c;
        h       = hist_q;
        c       = seed_q;
        err_raw = 1'b0;
        for (int i = 0; i < WORD_W; i++) begin
            if (c < SEED_CW'(ORDER)) begin
                c = c + SEED_CW'(1);
            end else if (predict_bit(h) != rx_word[i]) begin
                err_raw = 1'b1;
            end
            h = push_bit(h, rx_word[i]);
        end
        hist_n = h;
        seed_n = c;
    end

    assign word_err = prbs_en & err_raw;

    // Keep history and seed count; clear both when idle.
    always_ff @(posedge clk) begin
        if (!rst_n || !prbs_en) begin
            hist_q <= '0;
            seed_q <= '0;
        end else begin
            hist_q <= hist_n;
            seed_q <= seed_n;
        end
    end
endmodule

// File: rtl/prbs7_status.sv
// Pass/fail register: live mode copies the last word's result, held mode
// keeps the first failure until the test is stopped or reset.
module prbs7_status (
    input  logic clk,
    input  logic rst_n,
    input  logic prbs_en,
    input  logic latch_fail,
    input  logic word_err,
    output logic status_ok
);
    // Update the single status bit from the current word's result.
    always_ff @(posedge clk) begin
        if (!rst_n || !prbs_en) begin
            status_ok <= 1'b1;
        end else if (latch_fail) begin
            status_ok <= status_ok & ~word_err;
        end else begin
            status_ok <= ~word_err;
        end
    end
endmodule

// File: rtl/prbs7_bert.sv
// Top of the PRBS-7 test engine: generator, checker and status register.
// Assumes one received word per clock while prbs_en is high.
module prbs7_bert #(
    parameter int WORD_W = 10
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              prbs_en,
    input  logic              latch_fail,
    input  logic [WORD_W-1:0] rx_word,
    output logic [WORD_W-1:0] tx_word,
    output logic              status_ok
);
    logic word_err;

    prbs7_tx_gen #(.WORD_W(WORD_W)) u_gen (
        .clk     (clk),
        .rst_n   (rst_n),
        .prbs_en (prbs_en),
        .tx_word (tx_word)
    );

    prbs7_rx_chk #(.WORD_W(WORD_W)) u_chk (
        .clk      (clk),
        .rst_n    (rst_n),
        .prbs_en  (prbs_en),
        .rx_word  (rx_word),
        .word_err (word_err)
    );

    prbs7_status u_stat (
        .clk        (clk),
        .rst_n      (rst_n),
        .prbs_en    (prbs_en),
        .latch_fail (latch_fail),
        .word_err   (word_err),
        .status_ok  (status_ok)
    );
endmodule

// File: rtl/prbs7_bert_chk.sv
// Property checker for prbs7_bert, attached with bind below.
module prbs7_bert_chk #(
    parameter int WORD_W = 10
) (
    input logic              clk,
    input logic              rst_n,
    input logic              prbs_en,
    input logic              latch_fail,
    input logic              word_err,
    input logic [WORD_W-1:0] tx_word,
    input logic              status_ok
);
    // R1
    idle_quiet_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !prbs_en |=> (tx_word == '0 && status_ok));

    // R2
    gen_nonzero_chk: assert property (@(posedge clk) disable iff (!rst_n)
        ($past(prbs_en) && $past(rst_n)) |-> tx_word != '0);

    // R5
    err_drops_status_chk: assert property (@(posedge clk) disable iff (!rst_n)
        word_err |=> !status_ok);

    // R7
    live_recover_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (prbs_en && !latch_fail && !word_err) |=> status_ok);

    // R8
    held_fail_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (prbs_en && latch_fail && !status_ok) |=> !status_ok);

    // R10
    reset_state_chk: assert property (@(posedge clk)
        !rst_n |=> (status_ok && tx_word == '0));
endmodule

bind prbs7_bert prbs7_bert_chk #(.WORD_W(WORD_W)) u_props (
    .clk        (clk),
    .rst_n      (rst_n),
    .prbs_en    (prbs_en),
    .latch_fail (latch_fail),
    .word_err   (word_err),
    .tx_word    (tx_word),
    .status_ok  (status_ok)
);

// File: tb/prbs7_bert_test.sv
// Bench for prbs7_bert: a scenario table walked by one loop, then directed tests.
module prbs7_bert_test;
    localparam int W = 10;

    logic         clk = 1'b0;
    logic         rst_n;
    logic         en;
    logic         latch;
    logic [W-1:0] rx;
    logic [W-1:0] tx;
    logic         status;

    int checks = 0;
    int errors = 0;

    always #10 clk = ~clk;

    prbs7_bert #(.WORD_W(W)) uut (
        .clk        (clk),
        .rst_n      (rst_n),
        .prbs_en    (en),
        .latch_fail (latch),
        .rx_word    (rx),
        .tx_word    (tx),
        .status_ok  (status)
    );

    // Scenario: {latch, phase[7], err_word[8] (255 = none), err_bit[4], nwords[8], final_status}
    localparam logic [28:0] SCEN [6] = '{
        {1'b0, 7'd0,   8'd255, 4'd0, 8'd140, 1'b1},
        {1'b0, 7'd37,  8'd5,   4'd2, 8'd20,  1'b1},
        {1'b1, 7'd100, 8'd5,   4'd9, 8'd20,  1'b0},
        {1'b1, 7'd3,   8'd255, 4'd0, 8'd20,  1'b1},
        {1'b0, 7'd64,  8'd0,   4'd8, 8'd12,  1'b1},
        {1'b1, 7'd11,  8'd0,   4'd3, 8'd12,  1'b0}
    };

    task automatic check(input bit ok, input string req, input string what,
                         input int act, input int exp);
        checks++;
        if (!ok) begin
            errors++;
            $display("FAIL %s %s: actual=%0h expected=%0h", req, what, act, exp);
        end
    endtask

    // Reference sequence: b[n] = b[n-6] ^ b[n-7], newest bit in h[0].
    task automatic ref_word(inout logic [6:0] h, output logic [W-1:0] w);
        for (int i = 0; i < W; i++) begin
            w[i] = h[5] ^ h[6];
            h    = {h[5:0], w[i]};
        end
    endtask

    task automatic run_scen(input logic [28:0] v);
        bit           lt    = v[28];
        int           ph    = int'(v[27:21]);
        int           ew    = int'(v[20:13]);
        int           eb    = int'(v[12:9]);
        int           nw    = int'(v[8:1]);
        bit           fin   = v[0];
        logic [6:0]   rh    = '1;
        logic [6:0]   gh    = '1;
        logic [6:0]   mh    = '0;
        int           mcnt  = 0;
        bit           stick = 0;
        bit           saw   = 0;
        bit           werr;
        bit           exp_st;
        logic [W-1:0] w;
        logic [W-1:0] gw;
        logic [W-1:0] first_tx = '0;
        for (int s = 0; s < ph; s++) rh = {rh[5:0], rh[5] ^ rh[6]};
        @(negedge clk);
        latch = lt;
        en    = 1'b1;
        for (int k = 0; k < nw; k++) begin
            ref_word(rh, w);
            if (k == ew) w[eb] = ~w[eb];
            rx   = w;
            werr = 1'b0;
            for (int i = 0; i < W; i++) begin
                if (mcnt < 7) mcnt++;
                else if ((mh[5] ^ mh[6]) != w[i]) werr = 1'b1;
                mh = {mh[5:0], w[i]};
            end
            ref_word(gh, gw);
            @(negedge clk);
            stick  = stick | werr;
            exp_st = lt ? !stick : !werr;
            if (!status) saw = 1'b1;
            if (lt) check(status === exp_st, "R8", "held status", status, exp_st);
            else    check(status === exp_st, "R7", "live status", status, exp_st);
            check(tx === gw, "R2", "generated word", tx, gw);
            if (k == 0) begin
                first_tx = tx;
                if (ph == 0) check(tx === 10'h040, "R2", "first word", tx, 10'h040);
            end
            if (k == 1 && ph == 0) check(tx === 10'h10C, "R2", "second word", tx, 10'h10C);
            if (k == 127) check(tx === first_tx, "R3", "word 127 vs word 0", tx, first_tx);
        end
        if (ew == 255) check(saw == 1'b0, "R4", "clean stream flagged", saw, 0);
        else           check(saw == 1'b1, "R5", "injected error seen", saw, 1);
        check(status === fin, lt ? "R8" : "R7", "final status", status, fin);
        en = 1'b0;
        rx = 10'h2A7;
        @(negedge clk);
        check(status === 1'b1, "R9", "status after stop", status, 1);
        check(tx === '0, "R1", "tx after stop", tx, 0);
    endtask

    initial begin
        repeat (100000) @(posedge clk);
        errors++;
        checks++;
        $display("FAIL watchdog: actual=timeout expected=finish");
        $display("Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    end

    initial begin
        rst_n = 1'b0;
        en    = 1'b0;
        latch = 1'b0;
        rx    = '0;
        repeat (3) @(negedge clk);
        check(tx === '0, "R10", "tx in reset", tx, 0);
        check(status === 1'b1, "R10", "status in reset", status, 1);
        rst_n = 1'b1;

        // R1: idle with garbage on the receive side.
        for (int i = 0; i < 4; i++) begin
            rx = W'(10'h3FF ^ (i * 10'h155));
            @(negedge clk);
            check(status === 1'b1, "R1", "idle status", status, 1);
            check(tx === '0, "R1", "idle tx", tx, 0);
        end

        for (int s = 0; s < 6; s++) run_scen(SCEN[s]);

        // R6: a failing word only shows after the edge that samples it.
        latch = 1'b0;
        en    = 1'b1;
        rx    = 10'h3FF;
        #5;
        check(status === 1'b1, "R6", "status before edge", status, 1);
        @(negedge clk);
        check(status === 1'b0, "R6", "status after edge", status, 0);

        // R10: reset clears a held failure.
        latch = 1'b1;
        @(negedge clk);
        check(status === 1'b0, "R8", "held before reset", status, 0);
        rst_n = 1'b0;
        @(negedge clk);
        check(status === 1'b1, "R10", "reset clears held", status, 1);
        check(tx === '0, "R10", "reset clears tx", tx, 0);
        rst_n = 1'b1;
        en    = 1'b0;
        @(negedge clk);

        $display("Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    end
endmodule